// File: doc/BRIEF.md
# Read-Priority Write-Deferral Request Reorderer

This block sits in front of a DRAM memory controller and takes one in-order stream of cacheline requests from the masters. Write requests are not passed on when they arrive. They wait in a small write queue, so that read requests can reach the controller first. Grouping reads ahead of parked writes cuts read/write bus turnarounds. It also cuts row conflicts in the controller's banks, where each change of row in a bank costs a precharge and an activate.

Correctness is kept by an address check. A pending read is compared against every parked write at cacheline granularity. If it matches any of them, the read must not overtake. The queued writes are then issued in their original order until none of them matches, and only then is the read released. A state machine chooses each cycle between issuing the read, draining writes for a hazard, draining to a low watermark after the queue fills, and a flush that empties the queue. Both sides use valid/ready channels. Addresses are cacheline indices, and each request carries one full line.

Top module: `rr_reorder`

## Requirements
- R1: An accepted write is held in a queue of DEPTH entries and is never presented downstream in the cycle it is accepted. With mem_ready_i low, DEPTH writes are accepted without any downstream handshake.
- R2: A pending read whose line matches no parked write is issued before every parked write, except a write that is already being presented and held unaccepted.
- R3: A pending read whose line matches a parked write is issued only after every parked write up to the youngest match has been issued. Writes younger than the youngest match follow the read.
- R4: Writes are issued in acceptance order, with their data unchanged. This holds also when two writes target the same line.
- R5: While the queue is full, writes are refused (req_ready_o low for a write). Once the queue fills, only writes are issued until the count is at or below drain_lwm_i. A read waits during this drain even if it has no hazard.
- R6: When no read is pending and the queue is not empty, a write is presented downstream.
- R7: While flush_i is high, no request is accepted. The queue is drained, and idle_o rises only when the queue is empty and no read is pending.
- R8: Once mem_valid_o is high and mem_ready_i is low, the next cycle presents the same request (kind, address and data).
- R9: After reset: idle_o=1, mem_valid_o=0 and req_ready_o=1.
- R10: While a read is pending, req_ready_o is low, so no later request can enter ahead of it.

Ports table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_valid_i | input | 1 | upstream request valid |
| req_ready_o | output | 1 | upstream request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | cacheline address |
| req_data_i | input | DW | write line data |
| mem_valid_o | output | 1 | downstream request valid |
| mem_ready_i | input | 1 | controller accepts request |
| mem_write_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | cacheline address |
| mem_data_o | output | DW | write data, zero for reads |
| drain_lwm_i | input | CW | queue count at which a full-queue drain stops |
| flush_i | input | 1 | drain all parked writes, block new requests |
| idle_o | output | 1 | queue empty and no read pending |

## Verification
Some properties are checked on every cycle by the assertions. These are the stability of a request held under back-pressure, the rule that a read is never issued while it matches a parked write, the blocking of upstream during a pending read or a flush, the queue never overflowing or underflowing, and the queue's valid flags agreeing with its count. The actual issue order can only be shown by the bench's scenarios. They sweep the number of parked writes, the position of the matching write, repeated lines and every low watermark, and compare the logged downstream sequence against the order computed from the requirements.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ORDER = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FLUSH = 2'd3
  } rr_state_e;
endpackage

// File: rtl/rr_wfifo.sv
module rr_wfifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 26,
  parameter int DW    = 256,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          match_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic             vld_q  [DEPTH];
  logic [DEPTH-1:0] vld_vec, hit;
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we, re;
    assign we = push_i && (wp_q == PW'(i));
    assign re = pop_i && (rp_q == PW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  vld_q[i] <= 1'b0;
      else if (we)  vld_q[i] <= 1'b1;
      else if (re)  vld_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (we) begin
        addr_q[i] <= addr_i;
        data_q[i] <= data_i;
      end
    end

    assign vld_vec[i] = vld_q[i];
    // parallel line compare against every parked write
    assign hit[i]     = vld_q[i] && (addr_q[i] == cmp_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop_i)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_addr_o = addr_q[rp_q];
  assign head_data_o = data_q[rp_q];
  assign count_o     = cnt_q;
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign match_o     = |hit;

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
  a_r4_vld_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vld_vec) == int'(cnt_q));
endmodule

// File: rtl/rr_rdslot.sv
module rr_rdslot #(
  parameter int AW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic          issue_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o
);
  logic          vld_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= 1'b0;
    else if (take_i)  vld_q <= 1'b1;
    else if (issue_i) vld_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (take_i) addr_q <= addr_i;
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;

  a_r10_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !vld_q);
  a_r10_issue_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> vld_q);
endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_vld_i,
  input  logic          hazard_i,
  input  logic          empty_i,
  input  logic          full_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] lwm_i,
  input  logic          push_i,
  input  logic          flush_i,
  input  logic          mem_ready_i,
  output logic          sel_wr_o,
  output logic          sel_rd_o,
  output logic          pop_o,
  output logic          rd_issue_o,
  output logic          acc_rd_o,
  output logic          acc_wr_o
);
  import rr_pkg::*;

  rr_state_e     state_q, state_d;
  logic          hold_q, hold_wr_q;
  logic          sel_wr, sel_rd;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (hold_q) begin
      sel_wr = hold_wr_q;
      sel_rd = !hold_wr_q;
    end else begin
      sel_wr = !empty_i && (state_q == ST_DRAIN || state_q == ST_FLUSH ||
                            !rd_vld_i || hazard_i);
      sel_rd = rd_vld_i && !sel_wr && (state_q != ST_DRAIN);
    end
  end

  assign pop_o      = sel_wr && mem_ready_i;
  assign rd_issue_o = sel_rd && mem_ready_i;
  assign cnt_nxt    = count_i + CW'(push_i) - CW'(pop_o);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (flush_i)                     state_d = ST_FLUSH;
        else if (cnt_nxt == CW'(DEPTH))  state_d = ST_DRAIN;
        else if (rd_vld_i && hazard_i)   state_d = ST_ORDER;
      end
      ST_ORDER: if (!(rd_vld_i && hazard_i)) state_d = ST_RUN;
      ST_DRAIN: if (cnt_nxt <= lwm_i)        state_d = ST_RUN;
      ST_FLUSH: if (!flush_i && empty_i && !rd_vld_i) state_d = ST_RUN;
      default:                               state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      hold_q    <= 1'b0;
      hold_wr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      hold_q    <= (sel_wr || sel_rd) && !mem_ready_i;
      hold_wr_q <= sel_wr;
    end
  end

  assign acc_rd_o = !rd_vld_i && !flush_i && (state_q != ST_FLUSH);
  assign acc_wr_o = acc_rd_o && !full_i && (state_q != ST_DRAIN);
  assign sel_wr_o = sel_wr;
  assign sel_rd_o = sel_rd;

  a_r3_rd_no_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |-> !hazard_i);
  a_r5_drain_no_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rd && !hold_q) |-> (state_q != ST_DRAIN));
  a_r5_drain_stays_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> !empty_i);
endmodule

// File: rtl/rr_reorder.sv
module rr_reorder #(
  parameter int DEPTH = 8,
  parameter int AW    = 26,
  parameter int DW    = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic [CW-1:0] drain_lwm_i,
  input  logic          flush_i,
  output logic          idle_o
);
  logic          push, rd_take, pop, rd_issue;
  logic          sel_wr, sel_rd, acc_rd, acc_wr;
  logic          rd_vld, hazard, full, empty;
  logic [AW-1:0] rd_addr, head_addr;
  logic [DW-1:0] head_data;
  logic [CW-1:0] count;

  assign req_ready_o = req_write_i ? acc_wr : acc_rd;
  assign push        = req_valid_i && req_ready_o && req_write_i;
  assign rd_take     = req_valid_i && req_ready_o && !req_write_i;

  rr_wfifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_wfifo (
    .clk_i, .rst_ni,
    .push_i(push), .addr_i(req_addr_i), .data_i(req_data_i),
    .pop_i(pop), .cmp_addr_i(rd_addr),
    .head_addr_o(head_addr), .head_data_o(head_data),
    .count_o(count), .full_o(full), .empty_o(empty), .match_o(hazard)
  );

  rr_rdslot #(.AW(AW)) i_rdslot (
    .clk_i, .rst_ni,
    .take_i(rd_take), .addr_i(req_addr_i), .issue_i(rd_issue),
    .vld_o(rd_vld), .addr_o(rd_addr)
  );

  rr_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni,
    .rd_vld_i(rd_vld), .hazard_i(hazard && rd_vld), .empty_i(empty),
    .full_i(full), .count_i(count), .lwm_i(drain_lwm_i), .push_i(push),
    .flush_i, .mem_ready_i,
    .sel_wr_o(sel_wr), .sel_rd_o(sel_rd), .pop_o(pop), .rd_issue_o(rd_issue),
    .acc_rd_o(acc_rd), .acc_wr_o(acc_wr)
  );

  assign mem_valid_o = sel_wr || sel_rd;
  assign mem_write_o = sel_wr;
  assign mem_addr_o  = sel_wr ? head_addr : rd_addr;
  assign mem_data_o  = sel_wr ? head_data : '0;
  assign idle_o      = empty && !rd_vld;

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_write_o) && $stable(mem_addr_o) && $stable(mem_data_o)));
  a_r10_rd_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld |-> !req_ready_o);
  a_r7_flush_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_valid_o);
endmodule

// File: tb/test_rr_reorder.sv
module test_rr_reorder;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_ready = 1'b0, flush = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] lwm = '0;
  logic req_ready_o, mem_valid_o, mem_write_o, idle_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;

  int checks = 0, errors = 0;
  logic          lg_wr   [64];
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_data [64];
  int            lg_n = 0;
  logic          ex_wr   [64];
  logic [AW-1:0] ex_addr [64];
  int            ex_n = 0;

  always #(CLK_P/2) clk = ~clk;

  rr_reorder #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_rr_reorder (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o, .req_write_i(req_write),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .mem_valid_o, .mem_ready_i(mem_ready), .mem_write_o, .mem_addr_o, .mem_data_o,
    .drain_lwm_i(lwm), .flush_i(flush), .idle_o
  );

  function automatic logic [DW-1:0] mk(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction

  // sample just before each rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n && mem_valid_o && mem_ready && lg_n < 64) begin
      lg_wr[lg_n] = mem_write_o; lg_addr[lg_n] = mem_addr_o; lg_data[lg_n] = mem_data_o;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_add(input logic wr, input logic [AW-1:0] a);
    ex_wr[ex_n] = wr; ex_addr[ex_n] = a; ex_n++;
  endtask

  task automatic clear_logs();
    lg_n = 0; ex_n = 0;
  endtask

  task automatic push(input logic wr, input logic [AW-1:0] a);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data = mk(a);
    #1;
    while (!req_ready_o && n < 50) begin @(negedge clk); #1; n++; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic release_and_compare(input string tag);
    @(negedge clk); mem_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(lg_n == ex_n, {tag, " count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      chk(lg_wr[i] == ex_wr[i] && lg_addr[i] == ex_addr[i], {tag, " order"},
          {lg_wr[i], lg_addr[i]}, {ex_wr[i], ex_addr[i]});
      if (lg_wr[i]) chk(lg_data[i] == mk(lg_addr[i]), "R4 data", lg_data[i], mk(lg_addr[i]));
    end
    #1;
    chk(idle_o == 1'b1, {tag, " idle after"}, idle_o, 1);
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(idle_o == 1'b1,      "R9 idle",  idle_o, 1);
    chk(mem_valid_o == 1'b0, "R9 valid", mem_valid_o, 0);
    chk(req_ready_o == 1'b1, "R9 ready", req_ready_o, 1);
    rst_n = 1'b1;
    lwm = CW'(1);

    // R1: write not forwarded in its accept cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h05; req_data = mk(8'h05);
    #1;
    chk(mem_valid_o == 1'b0, "R1 not forwarded", mem_valid_o, 0);
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk); #1;
    chk(mem_valid_o && mem_write_o, "R6 write presented", {mem_valid_o, mem_write_o}, 3);
    clear_logs(); exp_add(1'b1, 8'h05);
    release_and_compare("R6");

    // R2/R4: no hazard, n parked writes
    for (int n = 1; n < DEPTH; n++) begin
      clear_logs();
      for (int i = 0; i < n; i++) push(1'b1, AW'(8'h10 + i));
      push(1'b0, 8'h80);
      #1;
      chk(req_ready_o == 1'b0, "R10 blocked", req_ready_o, 0);
      chk(mem_write_o == 1'b1 && mem_addr_o == 8'h10, "R8 held write", mem_addr_o, 8'h10);
      exp_add(1'b1, 8'h10); exp_add(1'b0, 8'h80);
      for (int i = 1; i < n; i++) exp_add(1'b1, AW'(8'h10 + i));
      release_and_compare("R2");
    end

    // R3: hazard at each position of three parked writes
    for (int p = 0; p < DEPTH - 1; p++) begin
      clear_logs();
      for (int i = 0; i < DEPTH - 1; i++) push(1'b1, AW'(8'h20 + i));
      push(1'b0, AW'(8'h20 + p));
      for (int i = 0; i <= p; i++) exp_add(1'b1, AW'(8'h20 + i));
      exp_add(1'b0, AW'(8'h20 + p));
      for (int i = p + 1; i < DEPTH - 1; i++) exp_add(1'b1, AW'(8'h20 + i));
      release_and_compare("R3");
    end

    // R3/R4: repeated line, read waits for the youngest copy
    clear_logs();
    push(1'b1, 8'h40); push(1'b1, 8'h41); push(1'b1, 8'h40);
    push(1'b0, 8'h40);
    exp_add(1'b1, 8'h40); exp_add(1'b1, 8'h41); exp_add(1'b1, 8'h40); exp_add(1'b0, 8'h40);
    release_and_compare("R4 dup");

    // R5: full queue, drain to each watermark
    for (int w = 0; w < DEPTH; w++) begin
      clear_logs();
      lwm = CW'(w);
      for (int i = 0; i < DEPTH; i++) push(1'b1, AW'(8'h60 + i));
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h6F; req_data = mk(8'h6F);
      #1;
      chk(req_ready_o == 1'b0, "R5 full refuses", req_ready_o, 0);
      @(negedge clk); req_valid = 1'b0;
      push(1'b0, 8'h90);
      for (int i = 0; i < DEPTH - w; i++) exp_add(1'b1, AW'(8'h60 + i));
      exp_add(1'b0, 8'h90);
      for (int i = DEPTH - w; i < DEPTH; i++) exp_add(1'b1, AW'(8'h60 + i));
      release_and_compare("R5");
    end

    // R7: flush
    clear_logs();
    push(1'b1, 8'hA0); push(1'b1, 8'hA1);
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 8'hB0;
    #1;
    chk(req_ready_o == 1'b0, "R7 flush blocks", req_ready_o, 0);
    chk(idle_o == 1'b0,      "R7 not idle",     idle_o, 0);
    @(negedge clk); req_valid = 1'b0;
    exp_add(1'b1, 8'hA0); exp_add(1'b1, 8'hA1);
    release_and_compare("R7");
    @(negedge clk); flush = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(req_ready_o == 1'b1, "R7 resumes", req_ready_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule